// File: doc/BRIEF.md
# SCSI Interrupt Status Latch

This block collects interrupt conditions raised on the SCSI side of a host adapter and holds each one in a sticky bit. The bits sit in two 8-bit status words. Each input is qualified in its own way before it can set a bit. A target disconnect counts only when the operating mode says it is unexpected. A selection timeout flags both its own bit and the disconnect bit. The bus reset line is detected on its rising edge. A receive parity error counts only while checking is enabled.

Firmware reads a status word through a small register port. The read returns every latched bit, whatever the mask says. The same read clears the bits it returned, but an event arriving in that very cycle is kept. Two 8-bit mask registers select which latched bits drive the single interrupt output.

The bus reset line passes through a synchronizer. An edge-tracking state machine follows it, with two states: `RS_IDLE` waits for the synchronized line to go high and moves to `RS_HELD` on that edge, and `RS_HELD` returns to `RS_IDLE` once the line drops. The read port is a second state machine with two states: `RP_IDLE` (no data) moves to `RP_RESP` whenever a read is requested, and `RP_RESP` (data valid) moves back to `RP_IDLE` when no read is requested.

Top module: `scsi_irq_latch`

## Requirements
- R1: After reset, both status words, both masks, `rd_valid` and `irq` are 0.
- R2: With `init_mode`=1 and `lowlvl_mode`=0, a `tgt_disc` strobe sets status word 0 bit 2 only when `disc_expected`=0; an expected disconnect leaves the bit clear.
- R3: With `lowlvl_mode`=1, every `tgt_disc` strobe sets status word 0 bit 2, whatever `disc_expected` and `init_mode` are.
- R4: With both mode flags 0, a `tgt_disc` strobe has no effect on status word 0.
- R5: A `sel_timeout` strobe sets status word 1 bit 2 and, on the same clock, status word 0 bit 2.
- R6: `bus_rst_line` passes through a 2-flop synchronizer. Each low-to-high transition sets status word 0 bit 1 exactly once, however long the line stays high.
- R7: A `par_err` strobe sets status word 0 bit 0 only while `par_chk_en`=1.
- R8: A `gp_expire` strobe sets status word 1 bit 1.
- R9: Status word 0 bits 7..3 and status word 1 bits 7..3 and bit 0 always read as 0.
- R10: A read with `rd_en`=1 returns data on `rd_data` with `rd_valid`=1 on the next cycle. The address map is 0 = status word 0, 1 = status word 1, 2 = mask 0, 3 = mask 1. Status words are returned raw, independent of the masks.
- R11: A status read clears the word it returned. A bit whose event arrives in the same cycle as the clearing read stays set.
- R12: The masks are 8-bit registers written with `wr_en` at addresses 2 and 3; writes to addresses 0 and 1 have no effect. `irq` is 1 exactly when some status bit and its matching mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_mode | input | 1 | Block operates as initiator |
| lowlvl_mode | input | 1 | Block operates in low-level mode |
| tgt_disc | input | 1 | Strobe: target left the bus |
| disc_expected | input | 1 | The current disconnect is a legitimate one |
| bus_rst_line | input | 1 | SCSI bus reset line level (asynchronous) |
| par_err | input | 1 | Strobe: receive parity error |
| par_chk_en | input | 1 | Parity checking enabled |
| sel_timeout | input | 1 | Strobe: selection or reselection timed out |
| gp_expire | input | 1 | Strobe: general-purpose timer expired |
| rd_en | input | 1 | Read request |
| rd_addr | input | 2 | Read address |
| wr_en | input | 1 | Write request |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid when `rd_valid` is 1 |
| rd_valid | output | 1 | Read data valid |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach from the ports is an event that lands in the same clock as the read that clears its word. The read must return the old value, and the bit must still be set afterwards. The bench raises `par_err` and `rd_en` on the same falling edge, then reads the word a second time. A long-held bus reset is a second hard case. The bench holds the line high for many cycles and reads twice, so that a missing edge qualifier would show up as a second event. A reference model runs alongside, clocked on every cycle, and tracks the synchronizer delay so that its prediction lines up with the design's output.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;

    localparam int DW = 8;
    localparam int AW = 2;

    // status word 0 bit positions
    localparam int S0_PAR  = 0;
    localparam int S0_BRST = 1;
    localparam int S0_DISC = 2;
    // status word 1 bit positions
    localparam int S1_GPT  = 1;
    localparam int S1_STO  = 2;

    localparam logic [DW-1:0] S0_IMPL = (DW'(1) << S0_PAR) | (DW'(1) << S0_BRST) | (DW'(1) << S0_DISC);
    localparam logic [DW-1:0] S1_IMPL = (DW'(1) << S1_GPT) | (DW'(1) << S1_STO);

    typedef enum logic [AW-1:0] {
        A_STAT0 = 2'd0,
        A_STAT1 = 2'd1,
        A_MASK0 = 2'd2,
        A_MASK1 = 2'd3
    } reg_addr_e;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_HELD = 1'b1
    } rst_state_e;

    typedef enum logic {
        RP_IDLE = 1'b0,
        RP_RESP = 1'b1
    } rp_state_e;

endpackage

// File: rtl/scsi_rst_edge.sv
module scsi_rst_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic pulse_o
);
    import scsi_irq_pkg::*;

    logic       line_s;
    rst_state_e state_q, state_d;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [SYNC_STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], line_i};
            end
            assign line_s = chain_q[SYNC_STAGES-1];
        end else begin : g_nosync
            assign line_s = line_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pulse_o = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
                if (line_s) begin
                    state_d = RS_HELD;
                    pulse_o = 1'b1;
                end
            end
            RS_HELD: begin
                if (!line_s) state_d = RS_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/scsi_evt_qual.sv
module scsi_evt_qual #(
    parameter int W = 8
) (
    input  logic         init_mode,
    input  logic         lowlvl_mode,
    input  logic         tgt_disc,
    input  logic         disc_expected,
    input  logic         rst_pulse,
    input  logic         par_err,
    input  logic         par_chk_en,
    input  logic         sel_timeout,
    input  logic         gp_expire,
    output logic [W-1:0] set0_o,
    output logic [W-1:0] set1_o
);
    import scsi_irq_pkg::*;

    logic disc_counts;

    always_comb begin
        // low-level mode reports every disconnect; initiator only unexpected ones
        disc_counts = tgt_disc && (lowlvl_mode || (init_mode && !disc_expected));

        set0_o          = '0;
        set0_o[S0_DISC] = disc_counts || sel_timeout;
        set0_o[S0_BRST] = rst_pulse;
        set0_o[S0_PAR]  = par_err && par_chk_en;

        set1_o          = '0;
        set1_o[S1_STO]  = sel_timeout;
        set1_o[S1_GPT]  = gp_expire;
    end

endmodule

// File: rtl/scsi_stat_reg.sv
module scsi_stat_reg #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (IMPL[i]) begin : g_impl
                always_ff @(posedge clk) begin
                    if (!rst_n)        q[i] <= 1'b0;
                    else if (set_i[i]) q[i] <= 1'b1;   // set wins over clear
                    else if (clr_i)    q[i] <= 1'b0;
                end
            end else begin : g_rsvd
                assign q[i] = 1'b0;
            end
        end
    endgenerate

    assign q_o = q;

endmodule

// File: rtl/scsi_reg_port.sv
module scsi_reg_port #(
    parameter int W = 8,
    parameter int A = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic [A-1:0] rd_addr,
    input  logic         wr_en,
    input  logic [A-1:0] wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] stat0_i,
    input  logic [W-1:0] stat1_i,
    output logic         clr0_o,
    output logic         clr1_o,
    output logic [W-1:0] mask0_o,
    output logic [W-1:0] mask1_o,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         irq
);
    import scsi_irq_pkg::*;

    rp_state_e    state_q, state_d;
    logic [W-1:0] mask0_q, mask1_q, rdata_q, rmux;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE: if (rd_en)  state_d = RP_RESP;
            RP_RESP: if (!rd_en) state_d = RP_IDLE;
        endcase
    end

    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            A_STAT0: rmux = stat0_i;
            A_STAT1: rmux = stat1_i;
            A_MASK0: rmux = mask0_q;
            A_MASK1: rmux = mask1_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask0_q <= '0;
            mask1_q <= '0;
            rdata_q <= '0;
        end else begin
            if (rd_en) rdata_q <= rmux;
            if (wr_en && reg_addr_e'(wr_addr) == A_MASK0) mask0_q <= wr_data;
            if (wr_en && reg_addr_e'(wr_addr) == A_MASK1) mask1_q <= wr_data;
        end
    end

    assign clr0_o   = rd_en && reg_addr_e'(rd_addr) == A_STAT0;
    assign clr1_o   = rd_en && reg_addr_e'(rd_addr) == A_STAT1;
    assign mask0_o  = mask0_q;
    assign mask1_o  = mask1_q;
    assign rd_data  = rdata_q;
    assign rd_valid = (state_q == RP_RESP);
    assign irq      = |(stat0_i & mask0_q) || |(stat1_i & mask1_q);

endmodule

// File: rtl/scsi_irq_latch.sv
module scsi_irq_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_mode,
    input  logic       lowlvl_mode,
    input  logic       tgt_disc,
    input  logic       disc_expected,
    input  logic       bus_rst_line,
    input  logic       par_err,
    input  logic       par_chk_en,
    input  logic       sel_timeout,
    input  logic       gp_expire,
    input  logic       rd_en,
    input  logic [1:0] rd_addr,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       irq
);
    import scsi_irq_pkg::*;

    logic          rst_pulse;
    logic [DW-1:0] set0, set1, stat0_q, stat1_q, mask0_q, mask1_q;
    logic          clr0, clr1;

    scsi_rst_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (bus_rst_line),
        .pulse_o (rst_pulse)
    );

    scsi_evt_qual #(.W(DW)) u_qual (
        .init_mode     (init_mode),
        .lowlvl_mode   (lowlvl_mode),
        .tgt_disc      (tgt_disc),
        .disc_expected (disc_expected),
        .rst_pulse     (rst_pulse),
        .par_err       (par_err),
        .par_chk_en    (par_chk_en),
        .sel_timeout   (sel_timeout),
        .gp_expire     (gp_expire),
        .set0_o        (set0),
        .set1_o        (set1)
    );

    scsi_stat_reg #(.W(DW), .IMPL(S0_IMPL)) u_stat0 (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set0),
        .clr_i (clr0),
        .q_o   (stat0_q)
    );

    scsi_stat_reg #(.W(DW), .IMPL(S1_IMPL)) u_stat1 (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set1),
        .clr_i (clr1),
        .q_o   (stat1_q)
    );

    scsi_reg_port #(.W(DW), .A(AW)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .stat0_i  (stat0_q),
        .stat1_i  (stat1_q),
        .clr0_o   (clr0),
        .clr1_o   (clr1),
        .mask0_o  (mask0_q),
        .mask1_o  (mask1_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .irq      (irq)
    );

endmodule

// File: rtl/scsi_irq_latch_chk.sv
module scsi_irq_latch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_pulse,
    input logic       par_err,
    input logic       par_chk_en,
    input logic       sel_timeout,
    input logic       gp_expire,
    input logic       rd_en,
    input logic [1:0] rd_addr,
    input logic       rd_valid,
    input logic [7:0] stat0_q,
    input logic [7:0] stat1_q
);

    // R10
    rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R10
    rd_valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R5
    sto_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_timeout |=> (stat1_q[2] && stat0_q[2]));

    // R7
    par_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && par_chk_en) |=> stat0_q[0]);

    // R7
    par_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat0_q[0] && !(par_err && par_chk_en)) |=> !stat0_q[0]);

    // R6
    rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);

    // R11
    clr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 2'd1 && !sel_timeout && !gp_expire) |=> (stat1_q == 8'h00));

    // R8
    gpt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gp_expire |=> stat1_q[1]);

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0_q[7:3] == 5'd0) && (stat1_q[7:3] == 5'd0) && !stat1_q[0]);

endmodule

bind scsi_irq_latch scsi_irq_latch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_pulse   (rst_pulse),
    .par_err     (par_err),
    .par_chk_en  (par_chk_en),
    .sel_timeout (sel_timeout),
    .gp_expire   (gp_expire),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_valid    (rd_valid),
    .stat0_q     (stat0_q),
    .stat1_q     (stat1_q)
);

// File: tb/scsi_irq_latch_bench.sv
`timescale 1ns/1ps
module scsi_irq_latch_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_mode = 0, lowlvl_mode = 0, tgt_disc = 0, disc_expected = 0;
    logic       bus_rst_line = 0, par_err = 0, par_chk_en = 0, sel_timeout = 0, gp_expire = 0;
    logic       rd_en = 0, wr_en = 0;
    logic [1:0] rd_addr = 0, wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       rd_valid, irq;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    scsi_irq_latch u_scsi_irq_latch (
        .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .lowlvl_mode(lowlvl_mode),
        .tgt_disc(tgt_disc), .disc_expected(disc_expected), .bus_rst_line(bus_rst_line),
        .par_err(par_err), .par_chk_en(par_chk_en), .sel_timeout(sel_timeout),
        .gp_expire(gp_expire), .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq)
    );

    // behavioural reference model
    logic [7:0] m_s0, m_s1, m_k0, m_k1, m_rd;
    logic       m_v;
    bit         m_sync[$];
    bit         m_high;

    always @(posedge clk) begin
        bit p; bit d;
        logic [7:0] e0, e1;
        if (!rst_n) begin
            m_s0 = 0; m_s1 = 0; m_k0 = 0; m_k1 = 0; m_rd = 0; m_v = 0;
            m_sync = '{0, 0}; m_high = 0;
        end else begin
            p = m_sync[1] && !m_high;
            m_high = m_sync[1];
            m_sync.pop_back();
            m_sync.push_front(bus_rst_line);
            d = tgt_disc && (lowlvl_mode || (init_mode && !disc_expected));
            e0 = {5'd0, d || sel_timeout, p, par_err && par_chk_en};
            e1 = {5'd0, sel_timeout, gp_expire, 1'b0};
            if (rd_en) begin
                case (rd_addr)
                    2'd0: m_rd = m_s0;
                    2'd1: m_rd = m_s1;
                    2'd2: m_rd = m_k0;
                    default: m_rd = m_k1;
                endcase
            end
            if (rd_en && rd_addr == 2'd0) m_s0 = 0;
            if (rd_en && rd_addr == 2'd1) m_s1 = 0;
            m_s0 = m_s0 | e0;
            m_s1 = m_s1 | e1;
            if (wr_en && wr_addr == 2'd2) m_k0 = wr_data;
            if (wr_en && wr_addr == 2'd3) m_k1 = wr_data;
            m_v = rd_en;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R12 irq vs model", {7'd0, irq}, {7'd0, (|(m_s0 & m_k0)) || (|(m_s1 & m_k1))});
            check("R10 rd_valid vs model", {7'd0, rd_valid}, {7'd0, m_v});
            if (m_v) check("R10 rd_data vs model", rd_data, m_rd);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        rd_en = 1; rd_addr = a;
        @(negedge clk);
        rd_en = 0;
        check(tag, {7'd0, rd_valid}, 8'd1);
        check(tag, rd_data, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic summary;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000 && !done) begin
                tests++; fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                summary();
            end
        end
    end

    initial begin
        idle(4);
        rst_n = 1;
        // R1 reset state
        check("R1 irq", {7'd0, irq}, 8'd0);
        check("R1 rd_valid", {7'd0, rd_valid}, 8'd0);
        rd(2'd0, 8'h00, "R1 stat0");
        rd(2'd1, 8'h00, "R1 stat1");
        rd(2'd2, 8'h00, "R1 mask0");
        rd(2'd3, 8'h00, "R1 mask1");

        // R2 initiator mode
        init_mode = 1; disc_expected = 1; tgt_disc = 1; idle(1); tgt_disc = 0;
        rd(2'd0, 8'h00, "R2 expected disconnect ignored");
        disc_expected = 0; tgt_disc = 1; idle(1); tgt_disc = 0;
        rd(2'd0, 8'h04, "R2 unexpected disconnect");
        rd(2'd0, 8'h00, "R11 cleared by read");

        // R3 low-level mode
        init_mode = 0; lowlvl_mode = 1; disc_expected = 1; tgt_disc = 1; idle(1); tgt_disc = 0;
        rd(2'd0, 8'h04, "R3 any disconnect");

        // R4 neither mode
        lowlvl_mode = 0; tgt_disc = 1; idle(1); tgt_disc = 0;
        rd(2'd0, 8'h00, "R4 disconnect ignored");

        // R5 selection timeout
        sel_timeout = 1; idle(1); sel_timeout = 0;
        rd(2'd1, 8'h04, "R5 timeout bit");
        rd(2'd0, 8'h04, "R5 disconnect bit");

        // R7 parity gating
        par_chk_en = 0; par_err = 1; idle(1); par_err = 0;
        rd(2'd0, 8'h00, "R7 parity disabled");
        par_chk_en = 1; par_err = 1; idle(1); par_err = 0;
        rd(2'd0, 8'h01, "R7 parity enabled");

        // R8 timer
        gp_expire = 1; idle(1); gp_expire = 0;
        rd(2'd1, 8'h02, "R8 timer expired");

        // R6 bus reset edge
        bus_rst_line = 1; idle(12);
        rd(2'd0, 8'h02, "R6 reset edge");
        idle(6);
        rd(2'd0, 8'h00, "R6 held line single event");
        bus_rst_line = 0; idle(4);
        bus_rst_line = 1; idle(4); bus_rst_line = 0;
        rd(2'd0, 8'h02, "R6 second edge");

        // R12 masks and irq
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'hFF);
        rd(2'd0, 8'h00, "R12 write to status ignored");
        rd(2'd2, 8'hFF, "R12 mask0 readback");
        check("R12 irq idle", {7'd0, irq}, 8'd0);
        par_err = 1; idle(1); par_err = 0;
        check("R12 irq raised", {7'd0, irq}, 8'd1);
        rd(2'd0, 8'h01, "R12 status under mask");
        check("R12 irq cleared", {7'd0, irq}, 8'd0);
        wr(2'd3, 8'h04);
        gp_expire = 1; idle(1); gp_expire = 0;
        check("R12 masked bit no irq", {7'd0, irq}, 8'd0);
        rd(2'd1, 8'h02, "R10 raw status ignores mask");

        // R11 event in the same cycle as the clearing read
        par_err = 1; idle(1); par_err = 0;
        par_err = 1; rd_en = 1; rd_addr = 2'd0;
        @(negedge clk);
        par_err = 0; rd_en = 0;
        check("R11 old value returned", rd_data, 8'h01);
        rd(2'd0, 8'h01, "R11 same-cycle event kept");

        // R9 reserved bits
        init_mode = 1; disc_expected = 0;
        tgt_disc = 1; par_err = 1; sel_timeout = 1; gp_expire = 1; bus_rst_line = 1;
        idle(1);
        tgt_disc = 0; par_err = 0; sel_timeout = 0; gp_expire = 0;
        idle(4);
        rd(2'd1, 8'h06, "R9 stat1 reserved zero");
        rd(2'd0, 8'h07, "R9 stat0 reserved zero");
        bus_rst_line = 0;
        idle(3);
        summary();
    end

endmodule